// File: doc/BRIEF.md
# Activity-Triggered Power-Down Controller

This block sits beside a memory array and decides when the array's sense and decode circuitry needs power. It samples the memory-side control and data inputs once per clock, compares them with the values held from the previous clock, and treats certain qualified transitions as activity. Each piece of activity raises the power enable and loads a timeout counter. When no further activity arrives before the counter runs out, the power enable drops again. Power therefore follows the rate of accesses and not the length of time the select input stays low.

Select, write strobe and clear are all active low. A falling edge of clear counts as activity. While clear is held low, it also masks every other kind of activity. A one-cycle status pulse reports that activity was seen. The timeout length and the address and data widths are parameters.

Top module: `pd_activity_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after its synchronised release, `pwr_en` and `wake` are 0. The timeout counter starts at zero.
- R2: A falling edge of `sel_n` (1 in the previous sample, 0 in the current one) is activity.
- R3: A falling edge of `wr_n` is activity only when `sel_n` is 0 in the current sample. With `sel_n` at 1 it has no effect.
- R4: A change of any bit of `addr` is activity only while `sel_n` is 0.
- R5: A change of any bit of `din` is activity only while both `sel_n` and `wr_n` are 0.
- R6: Activity at clock edge k loads the counter with TIMEOUT. `pwr_en` is 1 after edges k through k+TIMEOUT-1 and is 0 after edge k+TIMEOUT. New activity reloads the full value. Holding the inputs steady keeps nothing powered.
- R7: A falling edge of `clr_n` is activity. The block powers down TIMEOUT cycles later even when `clr_n` stays low.
- R8: While `clr_n` is 0, transitions on the other inputs are not activity. Releasing `clr_n` is not activity, and changes made during the clear are not seen as activity after the release.
- R9: `wake` is 1 for exactly the cycle after each edge at which activity was detected, and 0 otherwise.
- R10: The previous-sample registers reset to the idle pattern: `sel_n`=1, `wr_n`=1, `clr_n`=1, `addr`=0, `din`=0. So a `sel_n` held low through reset counts as a falling edge at the first working clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Memory select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | AW | Memory address |
| din | input | DW | Write data |
| clr_n | input | 1 | Array clear, active low |
| pwr_en | output | 1 | Array power enable |
| wake | output | 1 | One-cycle pulse after detected activity |

## Verification
An input change applied between clock edges is detected at the next rising edge. That same edge sets `pwr_en` and `wake`, so the bench drives on the falling edge and samples one nanosecond after the following rising edge. `pwr_en` is due to fall exactly TIMEOUT rising edges after the last activity. The bench keeps a cycle-by-cycle count of this from the requirements and compares both outputs after every edge. A sweep covers every combination of previous and current select and strobe levels, address change, data change and clear assertion. Each combination is followed until the timeout has drained completely.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // One flag per kind of qualified activity seen in a clock cycle.
  typedef struct packed {
    logic clr_fall;
    logic sel_fall;
    logic wr_fall;
    logic addr_chg;
    logic din_chg;
  } pd_cause_t;

endpackage

// File: rtl/pd_activity_detect.sv
module pd_activity_detect
  import pd_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          clr_n,
  output pd_cause_t     cause
);

  logic          prev_sel_n;
  logic          prev_wr_n;
  logic          prev_clr_n;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_din;
  pd_cause_t     cause_d;
  logic          mask;

  // Previous-sample registers track the inputs every cycle, including during clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_n <= 1'b1;
      prev_wr_n  <= 1'b1;
      prev_clr_n <= 1'b1;
      prev_addr  <= '0;
      prev_din   <= '0;
    end else begin
      prev_sel_n <= sel_n;
      prev_wr_n  <= wr_n;
      prev_clr_n <= clr_n;
      prev_addr  <= addr;
      prev_din   <= din;
    end
  end

  always_comb begin
    mask             = !clr_n;
    cause_d.clr_fall = prev_clr_n && !clr_n;
    cause_d.sel_fall = !mask && prev_sel_n && !sel_n;
    cause_d.wr_fall  = !mask && !sel_n && prev_wr_n && !wr_n;
    cause_d.addr_chg = !mask && !sel_n && (addr != prev_addr);
    cause_d.din_chg  = !mask && !sel_n && !wr_n && (din != prev_din);
  end

  assign cause = cause_d;

  // R8: while clear is low only the clear flag may be raised.
  a_r8_mask_others: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (cause.sel_fall == 1'b0 && cause.wr_fall == 1'b0 &&
                cause.addr_chg == 1'b0 && cause.din_chg == 1'b0));

  // R4: with the select high, address motion is never activity.
  a_r4_addr_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !cause.addr_chg && !cause.din_chg && !cause.wr_fall);

endmodule

// File: rtl/pd_timeout.sv
module pd_timeout #(
  parameter int TIMEOUT = 8,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);

  localparam logic [CW-1:0] FULL = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)                cnt_d = FULL;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R6: activity reloads the full interval.
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == FULL);

  // R6: without activity a running count steps down by one.
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6: an idle counter stays idle without activity.
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> cnt_q == '0);

  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/pd_activity_ctrl.sv
module pd_activity_ctrl
  import pd_pkg::*;
#(
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int TIMEOUT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          clr_n,
  output logic          pwr_en,
  output logic          wake
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  pd_cause_t              cause;
  logic                   any_act;
  logic                   wake_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  pd_activity_detect #(.AW(AW), .DW(DW)) u_detect (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .addr  (addr),
    .din   (din),
    .clr_n (clr_n),
    .cause (cause)
  );

  assign any_act = |cause;

  pd_timeout #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (any_act),
    .active (pwr_en)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) wake_q <= 1'b0;
    else            wake_q <= any_act;
  end
  assign wake = wake_q;

  // R2: a select falling edge outside clear powers the array.
  a_r2_sel_fall: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(sel_n) && clr_n && $past(clr_n)) |=> pwr_en && wake);

  // R7: asserting clear powers the array.
  a_r7_clear_wakes: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(clr_n) |=> pwr_en);

  // R9: a wake pulse always comes with power.
  a_r9_wake_powered: assert property (@(posedge clk) disable iff (!rst_int_n)
    wake |-> pwr_en);

  // R6: power rises only together with a wake pulse.
  a_r6_rise_needs_wake: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pwr_en) |-> wake);

endmodule

// File: tb/pd_activity_ctrl_tb_top.sv
`timescale 1ns/1ps
module pd_activity_ctrl_tb_top;

  localparam int AW = 4;
  localparam int DW = 4;
  localparam int T  = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, wr_n, clr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          pwr_en, wake;

  int checks = 0;
  int errors = 0;

  // Bench-side model state, built from the requirements.
  logic          m_sel_n, m_wr_n, m_clr_n;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_din;
  int            m_cnt;

  always #4 clk = ~clk;

  pd_activity_ctrl #(.AW(AW), .DW(DW), .TIMEOUT(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
    .addr(addr), .din(din), .clr_n(clr_n), .pwr_en(pwr_en), .wake(wake)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_idle();
    m_sel_n = 1'b1; m_wr_n = 1'b1; m_clr_n = 1'b1;
    m_addr = '0; m_din = '0; m_cnt = 0;
  endtask

  // Drive one cycle of inputs, advance the model, and compare both outputs.
  task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic c, input string force_tag);
    logic  cf, sf, wf, ac, dc, trig;
    string tag;
    @(negedge clk);
    sel_n = s; wr_n = w; addr = a; din = d; clr_n = c;
    cf = m_clr_n && !c;
    sf = c && m_sel_n && !s;
    wf = c && !s && m_wr_n && !w;
    ac = c && !s && (a != m_addr);
    dc = c && !s && !w && (d != m_din);
    trig = cf || sf || wf || ac || dc;
    if (trig) m_cnt = T;
    else if (m_cnt > 0) m_cnt--;
    if (force_tag != "")                                   tag = force_tag;
    else if (cf)                                           tag = "R7";
    else if (!c && ((m_sel_n && !s) || a != m_addr || d != m_din)) tag = "R8";
    else if (sf)                                           tag = "R2";
    else if (wf)                                           tag = "R3";
    else if (ac)                                           tag = "R4";
    else if (dc)                                           tag = "R5";
    else if (m_clr_n != c || (s && a != m_addr))           tag = "R8/R4";
    else                                                   tag = "R6";
    m_sel_n = s; m_wr_n = w; m_addr = a; m_din = d; m_clr_n = c;
    @(posedge clk); #1;
    check(tag, pwr_en, (m_cnt > 0));
    check("R9", wake, trig);
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step(m_sel_n, m_wr_n, m_addr, m_din, m_clr_n, "");
  endtask

  task automatic do_reset(input logic s_during);
    rst_n = 1'b0; sel_n = s_during; wr_n = 1'b1; clr_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", pwr_en, 1'b0);
    check("R1", wake, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int hi;
    // R1: reset state and first working cycle.
    do_reset(1'b1);
    @(posedge clk); #1;
    check("R1", pwr_en, 1'b0);
    check("R1", wake, 1'b0);
    repeat (2) @(negedge clk);
    model_idle();
    hold(2);

    // R6: count powered cycles after a single select edge.
    step(1'b0, 1'b1, 4'h0, 4'h0, 1'b1, "R2");
    hi = 1;
    for (int i = 0; i < T + 3; i++) begin
      step(1'b0, 1'b1, 4'h0, 4'h0, 1'b1, "R6");
      if (pwr_en) hi++;
    end
    check("R6", (hi == T), 1'b1);

    // R6: a reload in the middle restarts the interval.
    step(1'b0, 1'b1, 4'h1, 4'h0, 1'b1, "R4");
    hold(2);
    step(1'b0, 1'b1, 4'h2, 4'h0, 1'b1, "R4");
    hold(T + 1);

    // R8: clear masks activity and its release is silent.
    step(1'b1, 1'b1, 4'h2, 4'h0, 1'b1, "");
    hold(T + 1);
    step(1'b1, 1'b1, 4'h2, 4'h0, 1'b0, "R7");
    hold(T + 1);
    step(1'b0, 1'b0, 4'h9, 4'h7, 1'b0, "R8");
    hold(2);
    step(1'b0, 1'b0, 4'h9, 4'h7, 1'b1, "R8");
    hold(2);
    step(1'b1, 1'b1, 4'h9, 4'h7, 1'b1, "");
    hold(T + 1);

    // Sweep every previous/current combination of the qualified inputs.
    for (int p = 0; p < 128; p++) begin
      logic [AW-1:0] a0;
      logic [DW-1:0] d0;
      a0 = 4'h3; d0 = 4'h6;
      step(p[0], p[2], a0, d0, 1'b1, "");
      hold(T + 1);
      step(p[1], p[3], p[4] ? (a0 ^ 4'h1) : a0, p[5] ? (d0 ^ 4'h2) : d0, p[6], "");
      hold(T + 2);
      step(m_sel_n, m_wr_n, m_addr, m_din, 1'b1, "");
      hold(T + 1);
    end

    // R10: select held low through reset is seen as a falling edge.
    do_reset(1'b0);
    repeat (4) @(posedge clk);
    #1;
    check("R10", pwr_en, 1'b1);
    repeat (T + 2) @(posedge clk);
    #1;
    check("R10", pwr_en, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule